// File: doc/BRIEF.md
# Four-Operand Carry-Save Adder

This block returns the exact sum of four unsigned operands. The operands go through two reduction levels. The first level compresses three operands into a partial-sum vector and a saved-carry vector. The second level folds the fourth operand into those two vectors. Each level is a row of independent full-adder cells with no carry path between neighbours. A carry produced at bit i is moved to weight i+1 and enters the next level there. Each cell is two half adders whose carries are ORed.

Only the final stage propagates carries. By default it is a two-tier carry-lookahead adder, with 4-bit groups whose group generate and propagate terms are merged at the upper tier. A parameter can replace it with a ripple chain of the same full-adder cells for comparison. The vectors are widened at each level so that no overflow bit is lost. With the default registered output, the total appears one clock after the operands are sampled.

Top module: `csa4_adder`

## Requirements
- R1: While `rst` is high at a rising edge, `sum_o` and `cout_o` become zero at that edge, whatever the operands are.
- R2: The first level takes `op_a`, `op_b` and `op_c`. The value of its partial-sum vector plus twice its carry vector equals op_a+op_b+op_c.
- R3: The second level takes the first-level partial sum, the first-level carry moved up one bit, and `op_d`. The value of its outputs, with its carries weighted one bit higher, equals the value of its inputs. Its carry out of the top bit is always zero.
- R4: The final adder takes the second-level sum vector and the shifted carry vector, with a zero carry into bit 0. It returns their exact sum.
- R5: With the registered output (default), {`cout_o`,`sum_o`} after a rising edge equals op_a+op_b+op_c+op_d as sampled at that edge, as a (W+2)-bit unsigned number. `cout_o` is the most significant bit.
- R6: The corner totals are exact. All operands zero gives 0. All operands at 2^W-1 gives 4*(2^W-1), which is 1020 for W=8, with `cout_o`=1.
- R7: The ripple-carry final stage and the lookahead final stage give identical outputs for every operand set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | W | Operand A, unsigned |
| op_b | input | W | Operand B, unsigned |
| op_c | input | W | Operand C, unsigned |
| op_d | input | W | Operand D, unsigned |
| sum_o | output | W+1 | Low W+1 bits of the total |
| cout_o | output | 1 | Carry-out, the top bit of the total |

## Verification
The hardest case to bring about is a carry that must travel through both saved-carry shifts and then across a lookahead group boundary. That only happens when the same bit is set in several operands and the bits above it are already loaded. The stimulus sets one bit position in all four operands at once, uses alternating and all-ones patterns that saturate every column, and runs a 3-bit copy of the block exhaustively. A long pseudo-random run then compares both final-stage variants against the arithmetic total.

// File: rtl/csa4_pkg.sv
package csa4_pkg;
  typedef enum logic {
    FINAL_RIPPLE    = 1'b0,
    FINAL_LOOKAHEAD = 1'b1
  } final_kind_e;

  localparam int unsigned LA_GROUP = 4;

  function automatic int unsigned group_count(input int unsigned width);
    return (width + LA_GROUP - 1) / LA_GROUP;
  endfunction
endpackage

// File: rtl/csa_fa_cell.sv
module csa_fa_cell (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic co
);
  logic hs0, hc0, hc1;

  // first half adder
  assign hs0 = x ^ y;
  assign hc0 = x & y;
  // second half adder
  assign s   = hs0 ^ z;
  assign hc1 = hs0 & z;
  assign co  = hc0 | hc1;
endmodule

// File: rtl/csa_level.sv
module csa_level #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  input  logic [N-1:0] z,
  output logic [N-1:0] psum,
  output logic [N:0]   pcar_sh
);
  // carry from cell i is given weight i+1; nothing chains inside the row
  assign pcar_sh[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_cell
    csa_fa_cell cell_i (
      .x  (x[i]),
      .y  (y[i]),
      .z  (z[i]),
      .s  (psum[i]),
      .co (pcar_sh[i+1])
    );
  end
endmodule

// File: rtl/csa_cla_adder.sv
module csa_cla_adder #(
  parameter int unsigned N = 9
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] sum,
  output logic         cout
);
  import csa4_pkg::*;

  localparam int unsigned G  = LA_GROUP;
  localparam int unsigned NG = group_count(N);

  logic [N-1:0] gen, prp;
  logic [NG-1:0] grp_g, grp_p;
  logic [NG:0]   grp_c;

  assign gen = a & b;
  assign prp = a ^ b;

  // lower tier: group generate / propagate, missing top bits act as pass-through
  always_comb begin
    logic gacc, pacc;
    for (int k = 0; k < NG; k++) begin
      gacc = 1'b0;
      pacc = 1'b1;
      for (int j = 0; j < G; j++) begin
        if (k*G + j < N) begin
          gacc = gen[k*G+j] | (prp[k*G+j] & gacc);
          pacc = pacc & prp[k*G+j];
        end
      end
      grp_g[k] = gacc;
      grp_p[k] = pacc;
    end
  end

  // upper tier: each group carry as a flat sum of products, carry-in tied low
  always_comb begin
    logic acc, term;
    grp_c[0] = 1'b0;
    for (int k = 1; k <= NG; k++) begin
      acc = 1'b0;
      for (int j = 0; j < k; j++) begin
        term = grp_g[j];
        for (int m = j + 1; m < k; m++) term = term & grp_p[m];
        acc = acc | term;
      end
      grp_c[k] = acc;
    end
  end

  // inside each group: bit carries expanded from the group carry
  always_comb begin
    logic acc, term;
    int base;
    for (int i = 0; i < N; i++) begin
      base = (i / G) * G;
      acc  = grp_c[i/G];
      for (int j = base; j < i; j++) acc = acc & prp[j];
      for (int j = base; j < i; j++) begin
        term = gen[j];
        for (int m = j + 1; m < i; m++) term = term & prp[m];
        acc = acc | term;
      end
      sum[i] = prp[i] ^ acc;
    end
  end

  assign cout = grp_c[NG];
endmodule

// File: rtl/csa_rca_adder.sv
module csa_rca_adder #(
  parameter int unsigned N = 9
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] sum,
  output logic         cout
);
  logic [N:0] chain;

  assign chain[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_bit
    csa_fa_cell cell_i (
      .x  (a[i]),
      .y  (b[i]),
      .z  (chain[i]),
      .s  (sum[i]),
      .co (chain[i+1])
    );
  end

  assign cout = chain[N];
endmodule

// File: rtl/csa4_adder.sv
module csa4_adder #(
  parameter int unsigned           W       = 8,
  parameter csa4_pkg::final_kind_e FINAL   = csa4_pkg::FINAL_LOOKAHEAD,
  parameter bit                    REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_c,
  input  logic [W-1:0] op_d,
  output logic [W:0]   sum_o,
  output logic         cout_o
);
  import csa4_pkg::*;

  localparam int unsigned L2W = W + 1;   // width of the second level
  localparam int unsigned TW  = W + 2;   // width of the exact total

  logic [W-1:0]   s1;
  logic [W:0]     c1_sh;
  logic [L2W-1:0] s2;
  logic [L2W:0]   c2_sh;
  logic [W:0]     fin_sum;
  logic           fin_cout;
  logic [W:0]     tot_sum;
  logic           tot_cout;

  csa_level #(.N(W)) lvl1_i (
    .x       (op_a),
    .y       (op_b),
    .z       (op_c),
    .psum    (s1),
    .pcar_sh (c1_sh)
  );

  csa_level #(.N(L2W)) lvl2_i (
    .x       ({1'b0, s1}),
    .y       (c1_sh),
    .z       ({1'b0, op_d}),
    .psum    (s2),
    .pcar_sh (c2_sh)
  );

  if (FINAL == FINAL_LOOKAHEAD) begin : g_cla
    csa_cla_adder #(.N(L2W)) fin_i (
      .a    (s2),
      .b    (c2_sh[L2W-1:0]),
      .sum  (fin_sum),
      .cout (fin_cout)
    );
  end else begin : g_rca
    csa_rca_adder #(.N(L2W)) fin_i (
      .a    (s2),
      .b    (c2_sh[L2W-1:0]),
      .sum  (fin_sum),
      .cout (fin_cout)
    );
  end

  // top saved carry can never be set; folding it keeps every bit accounted
  assign tot_sum  = fin_sum;
  assign tot_cout = fin_cout | c2_sh[L2W];

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        sum_o  <= '0;
        cout_o <= 1'b0;
      end else begin
        sum_o  <= tot_sum;
        cout_o <= tot_cout;
      end
    end

    assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
      !rst |=> {cout_o, sum_o} ==
               $past(TW'(op_a) + TW'(op_b) + TW'(op_c) + TW'(op_d)));

    assert_reset_R1: assert property (@(posedge clk)
      rst |=> (sum_o == '0) && !cout_o);
  end else begin : g_comb
    assign sum_o  = tot_sum;
    assign cout_o = tot_cout;
  end

  assert_level1_R2: assert property (@(posedge clk) disable iff (rst)
    TW'(s1) + TW'(c1_sh) == TW'(op_a) + TW'(op_b) + TW'(op_c));

  assert_level2_R3: assert property (@(posedge clk) disable iff (rst)
    TW'(s2) + TW'(c2_sh) == TW'(s1) + TW'(c1_sh) + TW'(op_d));

  assert_top_carry_zero_R3: assert property (@(posedge clk) disable iff (rst)
    c2_sh[L2W] == 1'b0);

  assert_final_R4: assert property (@(posedge clk) disable iff (rst)
    {fin_cout, fin_sum} == TW'(s2) + TW'(c2_sh[L2W-1:0]));
endmodule

// File: tb/csa4_adder_tb_top.sv
module csa4_adder_tb_top;
  import csa4_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] a = '0, b = '0, c = '0, d = '0;
  logic [8:0] sum_cla, sum_rca;
  logic       cout_cla, cout_rca;
  logic [3:0] sum_t;
  logic       cout_t;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [31:0] rng = 32'h1234_5679;

  always #4 clk = ~clk;   // 125 MHz

  csa4_adder #(.W(8), .FINAL(FINAL_LOOKAHEAD), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .op_a(a), .op_b(b), .op_c(c), .op_d(d),
    .sum_o(sum_cla), .cout_o(cout_cla));

  csa4_adder #(.W(8), .FINAL(FINAL_RIPPLE), .REG_OUT(1'b1)) rca_i (
    .clk(clk), .rst(rst), .op_a(a), .op_b(b), .op_c(c), .op_d(d),
    .sum_o(sum_rca), .cout_o(cout_rca));

  csa4_adder #(.W(3), .FINAL(FINAL_LOOKAHEAD), .REG_OUT(1'b1)) tiny_i (
    .clk(clk), .rst(rst), .op_a(a[2:0]), .op_b(b[2:0]), .op_c(c[2:0]),
    .op_d(d[2:0]), .sum_o(sum_t), .cout_o(cout_t));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (a=%0d b=%0d c=%0d d=%0d)",
               req, act, exp, a, b, c, d);
    end
  endtask

  // drive at a falling edge, check at the next falling edge (one register)
  task automatic run_vec(input logic [7:0] va, vb, vc, vd, input string req);
    int exp8, exp3;
    a = va; b = vb; c = vc; d = vd;
    exp8 = int'(va) + int'(vb) + int'(vc) + int'(vd);
    exp3 = int'(va[2:0]) + int'(vb[2:0]) + int'(vc[2:0]) + int'(vd[2:0]);
    @(negedge clk);
    chk(req, int'({cout_cla, sum_cla}), exp8);
    chk("R7 ripple vs total", int'({cout_rca, sum_rca}), exp8);
    chk({req, " (3-bit)"}, int'({cout_t, sum_t}), exp3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset wins over loaded operands
    a = 8'hFF; b = 8'hFF; c = 8'hFF; d = 8'hFF;
    @(negedge clk);
    chk("R1 reset sum", int'(sum_cla), 0);
    chk("R1 reset cout", int'(cout_cla), 0);
    chk("R1 reset ripple", int'({cout_rca, sum_rca}), 0);
    rst = 1'b0;

    // R6: corner totals
    run_vec(8'h00, 8'h00, 8'h00, 8'h00, "R6 all zero");
    run_vec(8'hFF, 8'hFF, 8'hFF, 8'hFF, "R6 all ones");
    chk("R6 carry-out on max", int'(cout_cla), 1);
    run_vec(8'hFF, 8'hFF, 8'hFF, 8'h00, "R6 three max");

    // R2: single set bit in one operand at a time
    for (int op = 0; op < 4; op++) begin
      for (int i = 0; i < 8; i++) begin
        logic [7:0] v;
        v = 8'(1 << i);
        run_vec(op == 0 ? v : 8'h00, op == 1 ? v : 8'h00,
                op == 2 ? v : 8'h00, op == 3 ? v : 8'h00, "R2 single bit");
      end
    end

    // R3/R4: same bit in all operands, saved carries reach i+1 and i+2
    for (int i = 0; i < 8; i++) begin
      logic [7:0] v;
      v = 8'(1 << i);
      run_vec(v, v, v, v, "R3 column of four");
      run_vec(v, v, v, 8'h00, "R4 column of three");
    end

    // R4: alternating patterns crossing group boundaries
    run_vec(8'h55, 8'hAA, 8'h55, 8'hAA, "R4 alternating");
    run_vec(8'hAA, 8'hAA, 8'hAA, 8'hAA, "R4 alternating high");
    run_vec(8'h0F, 8'hF0, 8'hFF, 8'h01, "R4 nibble split");

    // R2/R3: exhaustive over 3-bit operands
    for (int v = 0; v < 4096; v++) begin
      run_vec(8'(v & 7), 8'((v >> 3) & 7), 8'((v >> 6) & 7), 8'((v >> 9) & 7),
              "R3 exhaustive small");
    end

    // R5/R7: pseudo-random
    for (int n = 0; n < 10000; n++) begin
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      run_vec(rng[7:0], rng[15:8], rng[23:16], rng[31:24], "R5 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule